// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block turns a stream of 32-bit words from a transmit queue into a standard I2S serial audio stream, acting always as the bus master. It divides its master clock input by a programmable factor to make the bit clock, and it drives word select and serial data itself. Each queue word carries one channel sample. Words are taken in pairs, left then right. Only the low `res` bits of each word are sent, most significant first. Each channel slot is exactly `res` bit clocks long.

Software or a feeding engine sets the divide ratio and the resolution, fills the queue and raises `tx_en`. Every enable starts with one silent frame, left slot first, before any queued sample goes out. If the queue runs dry, the block sends silence instead of stalling. When `tx_en` drops, the frame in flight is completed and the bus then goes quiet.

Top module: `i2s_tx_serializer`

## Requirements
- R1: During and after reset, with `tx_en` low, `bclk`, `ws`, `sd` and `fifo_pop` are all 0 and no bit clock edges occur.
- R2: While running, `bclk` has a period of exactly 2*(ratio+2) master clock cycles, high and low halves equal.
- R3: A frame is two slots of `res` bit clocks each. A slot carries bits res-1 down to 0 of its word, MSB first. Word bits above res-1 are never sent.
- R4: A `res` value below 8 or above 32 is treated as 32.
- R5: After each rising of `tx_en` from idle, the first frame is all zeros, left slot first, and no word is popped for it.
- R6: `ws` is 0 for the left slot and 1 for the right slot. It changes on the falling `bclk` edge that presents the last bit of the previous slot, one bit clock ahead of the next MSB.
- R7: `sd` and `ws` change only on falling `bclk` edges and are stable at every rising edge.
- R8: If the queue is empty when a slot begins, that slot is all zeros and nothing is popped. `fifo_pop` is never high while `fifo_empty` is high.
- R9: Each data slot pops exactly one word, as a one-cycle `fifo_pop` pulse when the slot is loaded. Queued words fill the slots in order, alternating left and right.
- R10: When `tx_en` is cleared, the current frame is finished. After that, `bclk`, `ws` and `sd` stay 0 until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic and the bit clock divider run on it |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| ratio | input | 8 | Bit clock divide control: period is 2*(ratio+2) clk cycles |
| res | input | 6 | Sample resolution in bits (8..32, others mean 32) |
| fifo_data | input | 32 | Head word of the transmit queue (show-ahead) |
| fifo_empty | input | 1 | Transmit queue has no word |
| fifo_pop | output | 1 | Consume the head word in this cycle |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 = left, 1 = right |
| sd | output | 1 | Serial data |

## Verification
The embedded properties check four rules on every cycle. No pop happens on an empty queue or during the silent left slot. Pops happen only at the falling-edge update. Data and word select hold steady across each rising bit clock. The outputs stay quiet whenever the serializer is stopped. Some behaviours can only be shown by the bench's scenarios, which decode the serial stream at each rising bit clock and compare it bit by bit with a frame built from the queued words. These are the bit clock period, the slot length and resolution clamping, the MSB-first word content, the leading silent frame, zero fill on underrun, and completion of the last frame after disable.

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6,
  parameter int MIN_RES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RES_W-1:0]   res,
  input  logic [WORD_W-1:0]  fifo_data,
  input  logic               fifo_empty,
  output logic               fifo_pop,
  output logic               bclk,
  output logic               ws,
  output logic               sd
);

  localparam int CNT_W = RATIO_W + 1;

  logic              running;
  logic              bclk_q, ws_q, sd_q;
  logic [CNT_W-1:0]  div_cnt;
  logic [RES_W-1:0]  bit_cnt;
  logic              ch;
  logic              zero_frm;
  logic [WORD_W-1:0] sh;

  logic [RES_W-1:0]  res_eff, last_bit, nb;
  logic [CNT_W-1:0]  div_lim;
  logic              tick, fall, slot_end, stop, need_word, next_silent;
  logic [WORD_W-1:0] next_word, aligned;

  assign res_eff  = (res < RES_W'(MIN_RES) || res > RES_W'(WORD_W)) ? RES_W'(WORD_W) : res;
  assign last_bit = res_eff - RES_W'(1);
  assign nb       = bit_cnt + RES_W'(1);
  assign div_lim  = {1'b0, ratio} + CNT_W'(1);

  assign tick        = running && (div_cnt >= div_lim);
  assign fall        = tick && bclk_q;
  assign slot_end    = bit_cnt >= last_bit;
  assign stop        = fall && slot_end && ch && !tx_en;
  assign need_word   = fall && slot_end && !stop;
  assign next_silent = zero_frm && !ch;
  assign fifo_pop    = need_word && !next_silent && !fifo_empty;
  assign next_word   = fifo_pop ? fifo_data : '0;
  assign aligned     = next_word << (RES_W'(WORD_W) - res_eff);

  assign bclk = bclk_q;
  assign ws   = ws_q;
  assign sd   = sd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      bclk_q   <= 1'b0;
      ws_q     <= 1'b0;
      sd_q     <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      ch       <= 1'b0;
      zero_frm <= 1'b0;
      sh       <= '0;
    end else if (!running) begin
      bclk_q  <= 1'b0;
      ws_q    <= 1'b0;
      sd_q    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      ch      <= 1'b0;
      sh      <= '0;
      if (tx_en) begin
        running  <= 1'b1;
        zero_frm <= 1'b1;
      end
    end else begin
      div_cnt <= tick ? '0 : div_cnt + CNT_W'(1);
      if (tick)
        bclk_q <= !bclk_q;
      if (stop) begin
        running <= 1'b0;
        ws_q    <= 1'b0;
        sd_q    <= 1'b0;
        bit_cnt <= '0;
        ch      <= 1'b0;
      end else if (fall && slot_end) begin
        bit_cnt <= '0;
        ch      <= !ch;
        if (ch)
          zero_frm <= 1'b0;
        sd_q <= aligned[WORD_W-1];
        sh   <= aligned << 1;
        ws_q <= !ch;
      end else if (fall) begin
        bit_cnt <= nb;
        sd_q    <= sh[WORD_W-1];
        sh      <= sh << 1;
        ws_q    <= (nb == last_bit) ? !ch : ch;
      end
    end
  end

  p_pop_not_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  p_silent_no_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && next_silent) |-> !fifo_pop);

  p_pop_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (bclk_q && running));

  p_stable_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_q) |-> ($stable(sd_q) && $stable(ws_q)));

  p_quiet_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!bclk_q && !sd_q && !ws_q));

endmodule

// File: tb/i2s_tx_serializer_bench.sv
`timescale 1ns/1ps
module i2s_tx_serializer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [7:0]  ratio = '0;
  logic [5:0]  res = 6'd16;
  logic [31:0] fifo_data;
  logic        fifo_empty;
  logic        fifo_pop;
  logic        bclk, ws, sd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  i2s_tx_serializer u_i2s_tx_serializer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ratio(ratio), .res(res),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .bclk(bclk), .ws(ws), .sd(sd)
  );

  logic [31:0] mem [16];
  int rd = 0;
  int wr = 0;
  int pops = 0;
  assign fifo_data  = mem[rd % 16];
  assign fifo_empty = (rd == wr);
  always @(posedge clk) if (fifo_pop) begin rd <= rd + 1; pops <= pops + 1; end

  logic   rws [512];
  logic   rsd [512];
  longint rtm [512];
  int n = 0;
  always @(posedge bclk) begin
    if (n < 512) begin rws[n] = ws; rsd[n] = sd; rtm[n] = $time; end
    n = n + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wgen(input int seed, input int i);
    return {8'h80 | 8'(seed * 17 + i), 8'(i * 37 + 5), 8'hC3 ^ 8'(i), 8'(seed + i * 3) | 8'h01};
  endfunction

  task automatic test_reset();
    repeat (4) @(negedge clk);
    check(!bclk && !ws && !sd && !fifo_pop, "R1", "outputs in reset", {bclk, ws, sd, fifo_pop}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(!bclk && !ws && !sd && !fifo_pop, "R1", "outputs idle", {bclk, ws, sd, fifo_pop}, 0);
    check(n == 0, "R1", "no bit clock while disabled", n, 0);
  endtask

  // One enable/disable session: W words queued, enable dropped after rise T.
  task automatic run_session(input string tag, input int rt, input int rs,
                             input int w, input int seed, input int t);
    int r, f, exp_n, exp_pops, bad, s, i, c;
    logic [31:0] word, words[16];
    bit e_sd, e_ws;
    r = (rs < 8 || rs > 32) ? 32 : rs;
    @(negedge clk);
    ratio = 8'(rt); res = 6'(rs);
    rd = 0; wr = 0; pops = 0; n = 0;
    for (int k = 0; k < w; k++) begin words[k] = wgen(seed, k); mem[k] = words[k]; end
    wr = w;
    tx_en = 1'b1;
    wait (n == t);
    @(negedge clk);
    tx_en = 1'b0;
    repeat (2 * r * 2 * (rt + 2) + 40) @(negedge clk);
    f = (t - 1) / (2 * r) + 1;
    exp_n = f * 2 * r;
    exp_pops = (w < 2 * f - 2) ? w : 2 * f - 2;
    check(n == exp_n, "R10", {tag, " bit count, last frame finished"}, n, exp_n);
    check(!bclk && !ws && !sd, "R10", {tag, " quiet after disable"}, {bclk, ws, sd}, 0);
    check(pops == exp_pops, "R9", {tag, " pop count (R8 underrun pops nothing)"}, pops, exp_pops);
    bad = -1;
    for (int k = 1; k < exp_n && k < n; k++)
      if (bad < 0 && (rtm[k] - rtm[k-1]) != 2 * (rt + 2) * 5) bad = k;
    check(bad < 0, "R2", {tag, " bit clock period ns"},
          bad < 0 ? 0 : rtm[bad] - rtm[bad-1], 2 * (rt + 2) * 5);
    bad = -1;
    for (int k = 0; k < exp_n && k < n; k++) begin
      s = k / r; i = k % r; c = s % 2;
      word = (s < 2) ? 32'h0 : ((s - 2 < w) ? words[s-2] : 32'h0);
      e_sd = word[r - 1 - i];
      e_ws = (i == r - 1) ? !c[0] : c[0];
      if (bad < 0 && (rsd[k] !== e_sd || rws[k] !== e_ws)) begin
        bad = k;
        check(0, "R3", {tag, " stream bit (R5 silent frame, R6 ws, R4 res)"},
              {rws[k], rsd[k]}, {e_ws, e_sd});
      end
    end
    if (bad < 0) check(1, "R3", {tag, " stream"}, 0, 0);
  endtask

  initial begin
    test_reset();
    run_session("A r16", 2, 16, 4, 1, 2 * 16 * 3 + 5);
    run_session("B r32 underrun", 0, 32, 3, 2, 64 * 2 + 10);
    run_session("C r24 high bits", 1, 24, 4, 3, 48 * 2 + 3);
    run_session("D res5 clamp", 0, 5, 2, 4, 64 + 1);
    run_session("E res40 clamp", 3, 40, 2, 5, 64 + 7);
    run_session("F r8 restart", 0, 8, 6, 6, 16 * 3 + 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule